// File: doc/BRIEF.md
# Interrupt Cycle Controller

This block is the interrupt logic of a small accumulator machine. It keeps two state bits: an enable bit, which program instructions turn on and off, and a pending bit that records an accepted interrupt request. While enable is on, either of the two device ready flags sets the pending bit. The pending bit can only change on a clock edge that falls outside the three fetch steps of the instruction cycle.

When the pending bit is set, the controller takes over the next three fetch steps. In their place it runs a fixed hardware call. The current program counter is parked in the temporary register. That value is written to memory word 0. The program counter is then forced to 1, so the next instruction comes from word 1. On the final step the controller clears both enable and pending, and it resets the sequence counter. The surrounding datapath reads the strobes and performs the actual register and memory transfers. The `step` input carries the value of the machine's sequence counter.

Top module: `irq_cycle_ctrl`

## Requirements
- R1: With enable on, a clock edge where `step` is 3 or higher and `in_ready` or `out_ready` is 1 makes `pend` read 1 after that edge.
- R2: A clock edge where `step` is 0, 1 or 2 never changes `pend` from 0 to 1, whatever the flags and enable.
- R3: While enable reads 0, `pend` stays 0 whatever the ready flags do.
- R4: With `pend` at 0, `fetch_en` is 1 exactly while `step` is 0, 1 or 2, and every interrupt strobe is 0.
- R5: With `pend` at 1 and `step` equal to 0, `ar_clr` and `tr_from_pc` are 1, and every other strobe is 0.
- R6: With `pend` at 1 and `step` equal to 1, `mem_wr` and `pc_clr` are 1, and every other strobe is 0. The memory address is 0 because AR was cleared at step 0.
- R7: With `pend` at 1 and `step` equal to 2, `pc_inc`, `ien_drop` and `sc_clr` are 1. After that edge both `ien` and `pend` read 0.
- R8: `ien_set` turns enable on and `ien_clr` turns it off at the next edge. When both are 1 in the same cycle, the clear wins.
- R9: When `ien_set` arrives in the same cycle as the exit step of the sequence, `ien` still reads 0 after the edge.
- R10: Reset clears `ien` and `pend` at once.
- R11: Once set, `pend` stays 1 until the exit step, even if the ready flags and enable drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | SC_W | Current sequence counter value (0..2 are fetch steps) |
| in_ready | input | 1 | Input device ready flag |
| out_ready | input | 1 | Output device ready flag |
| ien_set | input | 1 | Instruction request to turn enable on |
| ien_clr | input | 1 | Instruction request to turn enable off |
| ien | output | 1 | Interrupt enable state |
| pend | output | 1 | Interrupt pending state |
| fetch_en | output | 1 | Normal fetch may run this step |
| ar_clr | output | 1 | Clear the address register |
| tr_from_pc | output | 1 | Load the temporary register from the program counter |
| mem_wr | output | 1 | Write the temporary register to memory at AR |
| pc_clr | output | 1 | Clear the program counter |
| pc_inc | output | 1 | Increment the program counter |
| ien_drop | output | 1 | Enable is being cleared by the sequence |
| sc_clr | output | 1 | Clear the sequence counter |

## Verification
The assertions assume that `step` advances the way a sequence counter does. In particular, they assume that steps 0, 1 and 2 of the interrupt sequence arrive in order while `pend` is held. They also assume that the exit step clears the counter. The stimulus table walks `step` through 3+, 0, 1, 2 in that order around every sequence. It holds the ready flags high across fetch steps to probe the blocked window, and it raises enable requests only at chosen edges. The table never drives a step value that skips part of an interrupt sequence, so the strobes seen on each step match the order the assertions expect.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Strobe bundle driven toward the datapath
  typedef struct packed {
    logic fetch;
    logic ar_clr;
    logic tr_ld;
    logic mem_wr;
    logic pc_clr;
    logic pc_inc;
    logic ien_drop;
    logic sc_clr;
  } irq_strobe_t;

  // Index of each interrupt step inside the fetch window
  localparam int unsigned STEP_SAVE  = 0;
  localparam int unsigned STEP_STORE = 1;
  localparam int unsigned STEP_EXIT  = 2;
  localparam int unsigned NUM_FETCH  = 3;

  // Request acceptance: enable on, a flag up, outside the fetch window
  function automatic logic accept_req(input logic en, input logic fin,
                                      input logic fout, input logic late);
    return en & (fin | fout) & late;
  endfunction

  // Enable next state: sequence exit dominates, then clear, then set
  function automatic logic next_enable(input logic en, input logic set_req,
                                       input logic clr_req, input logic exit_now);
    logic n;
    n = en;
    if (set_req) n = 1'b1;
    if (clr_req) n = 1'b0;
    if (exit_now) n = 1'b0;
    return n;
  endfunction

endpackage

// File: rtl/irq_step_decode.sv
module irq_step_decode #(
  parameter int unsigned SC_W    = 4,
  parameter int unsigned N_EARLY = 3
) (
  input  logic [SC_W-1:0]    step,
  output logic [N_EARLY-1:0] early,
  output logic               late
);

  for (genvar i = 0; i < N_EARLY; i++) begin : g_hit
    assign early[i] = (step == SC_W'(i));
  end

  assign late = ~|early;

  always_comb begin
    assert ($onehot0(early)) else $error("AST_STEP_ONEHOT"); // R4
  end

endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic late,
  input  logic in_ready,
  input  logic out_ready,
  input  logic ien_set,
  input  logic ien_clr,
  input  logic exit_now,
  output logic ien_q,
  output logic pend_q
);

  logic take_req;
  logic ien_d;

  assign take_req = accept_req(ien_q, in_ready, out_ready, late);
  assign ien_d    = next_enable(ien_q, ien_set, ien_clr, exit_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ien_q <= ien_d;
      if (exit_now)      pend_q <= 1'b0;
      else if (take_req) pend_q <= 1'b1;
    end
  end

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(ien_q)); // R3

  AST_NO_SET_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(late)); // R2

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exit_now |=> (!pend_q && !ien_q)); // R7

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !exit_now) |=> pend_q); // R11

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && ien_clr) |=> !ien_q); // R8

endmodule

// File: rtl/irq_seq_strobes.sv
module irq_seq_strobes
  import irq_pkg::*;
#(
  parameter int unsigned N_EARLY = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EARLY-1:0] early,
  input  logic               pend,
  output irq_strobe_t        stb,
  output logic               exit_now
);

  logic in_fetch;
  assign in_fetch = |early;

  always_comb begin
    stb          = '0;
    stb.fetch    = in_fetch & ~pend;
    stb.ar_clr   = pend & early[STEP_SAVE];
    stb.tr_ld    = pend & early[STEP_SAVE];
    stb.mem_wr   = pend & early[STEP_STORE];
    stb.pc_clr   = pend & early[STEP_STORE];
    stb.pc_inc   = pend & early[STEP_EXIT];
    stb.ien_drop = pend & early[STEP_EXIT];
    stb.sc_clr   = pend & early[STEP_EXIT];
  end

  assign exit_now = stb.sc_clr;

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.ar_clr, stb.mem_wr, stb.pc_inc})); // R5

  AST_FETCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.fetch |-> !(stb.ar_clr || stb.mem_wr || stb.pc_inc)); // R4

  AST_STORE_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.mem_wr |-> $past(stb.ar_clr)); // R6

endmodule

// File: rtl/irq_cycle_ctrl.sv
module irq_cycle_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned SC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SC_W-1:0] step,
  input  logic            in_ready,
  input  logic            out_ready,
  input  logic            ien_set,
  input  logic            ien_clr,
  output logic            ien,
  output logic            pend,
  output logic            fetch_en,
  output logic            ar_clr,
  output logic            tr_from_pc,
  output logic            mem_wr,
  output logic            pc_clr,
  output logic            pc_inc,
  output logic            ien_drop,
  output logic            sc_clr
);

  localparam int unsigned N_EARLY = NUM_FETCH;

  logic [N_EARLY-1:0] early;
  logic               late;
  logic               exit_now;
  irq_strobe_t        stb;

  irq_step_decode #(.SC_W(SC_W), .N_EARLY(N_EARLY)) u_dec (
    .step  (step),
    .early (early),
    .late  (late)
  );

  irq_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .late      (late),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .ien_set   (ien_set),
    .ien_clr   (ien_clr),
    .exit_now  (exit_now),
    .ien_q     (ien),
    .pend_q    (pend)
  );

  irq_seq_strobes #(.N_EARLY(N_EARLY)) u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .early    (early),
    .pend     (pend),
    .stb      (stb),
    .exit_now (exit_now)
  );

  assign fetch_en   = stb.fetch;
  assign ar_clr     = stb.ar_clr;
  assign tr_from_pc = stb.tr_ld;
  assign mem_wr     = stb.mem_wr;
  assign pc_clr     = stb.pc_clr;
  assign pc_inc     = stb.pc_inc;
  assign ien_drop   = stb.ien_drop;
  assign sc_clr     = stb.sc_clr;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!ien && !pend)); // R10

endmodule

// File: tb/irq_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cycle_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] step = '0;
  logic       in_ready = 1'b0, out_ready = 1'b0, ien_set = 1'b0, ien_clr = 1'b0;
  logic       ien, pend, fetch_en, ar_clr, tr_from_pc, mem_wr, pc_clr, pc_inc, ien_drop, sc_clr;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  irq_cycle_ctrl u_irq_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .step(step), .in_ready(in_ready), .out_ready(out_ready),
    .ien_set(ien_set), .ien_clr(ien_clr), .ien(ien), .pend(pend), .fetch_en(fetch_en),
    .ar_clr(ar_clr), .tr_from_pc(tr_from_pc), .mem_wr(mem_wr), .pc_clr(pc_clr),
    .pc_inc(pc_inc), .ien_drop(ien_drop), .sc_clr(sc_clr)
  );

  // Vector: step, in, out, set, clr, strobes before edge, pend after, ien after
  // Strobe order: fetch, ar_clr, tr, mem_wr, pc_clr, pc_inc, ien_drop, sc_clr
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R3 flags ignored, enable off
    {4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}, // R8 set
    {4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1}, // R2 blocked at step 0
    {4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1}, // R2 blocked at step 1
    {4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1}, // R2 blocked at step 2
    {4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // R1 accepted
    {4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // R11 hold
    {4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h60, 1'b1, 1'b1}, // R5
    {4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h18, 1'b1, 1'b1}, // R6
    {4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07, 1'b0, 1'b0}, // R7 R9
    {4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R4
    {4'd3, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}, // R3 enable was off at edge
    {4'd5, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0}, // R1 R8 clear wins
    {4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R11 hold without enable
    {4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h60, 1'b1, 1'b0}, // R5
    {4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h18, 1'b1, 1'b0}, // R6
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0}  // R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] strobes();
    return {fetch_en, ar_clr, tr_from_pc, mem_wr, pc_clr, pc_inc, ien_drop, sc_clr};
  endfunction

  initial begin
    #40000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    check("R10 reset ien/pend", {6'd0, ien, pend}, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {step, in_ready, out_ready, ien_set, ien_clr} = VEC[i][17:10];
      #1;
      check($sformatf("vec%0d strobes R4-R7", i), strobes(), VEC[i][9:2]);
      @(posedge clk);
      #1;
      check($sformatf("vec%0d R1 R2 R3 R8 R11 pend", i), {7'd0, pend}, {7'd0, VEC[i][1]});
      check($sformatf("vec%0d R8 R9 ien", i), {7'd0, ien}, {7'd0, VEC[i][0]});
    end
    // R10: reset while pending clears both
    @(negedge clk);
    {step, in_ready, out_ready, ien_set, ien_clr} = {4'd4, 1'b0, 1'b0, 1'b1, 1'b0};
    @(negedge clk);
    {step, in_ready, out_ready, ien_set, ien_clr} = {4'd4, 1'b1, 1'b0, 1'b0, 1'b0};
    @(negedge clk);
    check("R1 pend before reset", {7'd0, pend}, 8'h01);
    rst_n = 1'b0;
    #1;
    check("R10 reset mid pending", {6'd0, ien, pend}, 8'h00);
    @(negedge clk);
    in_ready = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {6'd0, ien, pend}, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule